// File: doc/BRIEF.md
# Response Packetizer with Status Header and Keepalive

This block sits between a JTAG engine that produces response bytes and a host link that moves data in short packets. Response bytes arrive one per cycle on a valid-qualified byte input. They are held in a 256-entry circular buffer until the host link can take them. The block then sends them as packets on a valid/ready byte stream. A last flag marks the final byte of each packet.

Every packet opens with two fixed status bytes, 0x31 then 0x60. At most 62 payload bytes follow, so a packet is never longer than 64 bytes. A new packet starts only while the link reports itself not busy. A timer-driven keepalive sends header-only packets at a fixed rate while nothing is pending. A header-only packet also follows any data packet, so that a short packet closes the transfer.

The block drives a throttle output to the command path. It allows more host input only while the buffer keeps enough headroom for a full packet's worth of responses. A write into a completely full buffer is lost and leaves a sticky overflow indication.

Top module: `pk_response_packetizer`

## Requirements
- R1: The first beat of every packet carries 0x31 and the second beat carries 0x60.
- R2: The payload length of a packet is fixed when the packet starts, as the smaller of the pending count and 62. Bytes that arrive after the start wait for a later packet.
- R3: pkt_last is high on the final beat of every packet, including the second beat of a header-only packet. While pkt_valid is high and pkt_ready is low, pkt_valid, pkt_data and pkt_last hold their values.
- R4: Payload bytes leave in the order they were written. Storage is a 256-entry circular buffer whose 8-bit read and write pointers wrap modulo 256.
- R5: With the link idle, nothing pending and pkt_ready high, a header-only packet starts once every CLK_HZ/TICK_HZ cycles.
- R6: Finishing a data packet requests a keepalive at once. Pending data is sent before any keepalive. With nothing pending and the link idle, a header-only packet's first beat appears 2 cycles after the final beat of the data packet.
- R7: While link_busy is high, no new packet starts. A packet already under way completes under pkt_ready control.
- R8: accept_more is high exactly when the pending count is below 193, which is the buffer length minus 63.
- R9: A write while 256 bytes are pending is discarded and does not disturb stored data. It sets overflow, which stays high until reset.
- R10: During and right after reset, pkt_valid is low, accept_more is high and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Response byte present this cycle |
| in_data | input | 8 | Response byte from the JTAG engine |
| link_busy | input | 1 | Host link cannot start a new packet |
| pkt_ready | input | 1 | Host link accepts the current beat |
| pkt_valid | output | 1 | Beat present on pkt_data |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final beat of the packet |
| accept_more | output | 1 | Command path may take more host input |
| overflow | output | 1 | Sticky flag: a write into a full buffer was lost |

## Verification
The bench builds the block with CLK_HZ of 4000 and TICK_HZ of 100. This gives a 40-cycle keepalive period, so the exact spacing of idle keepalives and their interaction with data packets can be measured in a short run. The buffer keeps its default 256 entries. Filling it completely, crossing the 193-entry throttle point, dropping a write at full and draining across the pointer wrap therefore all happen at the real sizes. Holding link_busy lets the bench stage exact pending counts, including 100 bytes split as 62 plus 38 and a length frozen while more bytes arrive.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_HDRA = 2'd1,
    PK_HDRB = 2'd2,
    PK_BODY = 2'd3
  } pk_state_e;

endpackage

// File: rtl/pk_ring.sv
module pk_ring #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] fill,
  output logic          drop
);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          full;
  logic          wr_ok;

  assign full  = (fill_q == CW'(DEPTH));
  assign wr_ok = wr_en & ~full;
  assign drop  = wr_en & full;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (wr_ok) begin
      wr_ptr_d = wr_ptr_q + AW'(1);
    end
    if (rd_en) begin
      rd_ptr_d = rd_ptr_q + AW'(1);
    end
    case ({wr_ok, rd_en})
      2'b10:   fill_d = fill_q + CW'(1);
      2'b01:   fill_d = fill_q - CW'(1);
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign fill    = fill_q;

endmodule

// File: rtl/pk_tick.sv
module pk_tick #(
  parameter int PERIOD = 480000,
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == TW'(PERIOD - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = wrap;

endmodule

// File: rtl/pk_former.sv
module pk_former
  import pk_pkg::*;
#(
  parameter int        CW      = 9,
  parameter int        MAX_PAY = 62,
  parameter logic [7:0] HDR_A  = 8'h31,
  parameter logic [7:0] HDR_B  = 8'h60,
  localparam int LW = $clog2(MAX_PAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_busy,
  input  logic [CW-1:0] fill,
  input  logic          ka_pending,
  input  logic [7:0]    rd_data,
  input  logic          pkt_ready,
  output logic          pkt_valid,
  output logic [7:0]    pkt_data,
  output logic          pkt_last,
  output logic          rd_en,
  output logic          ka_take,
  output logic          data_done
);

  pk_state_e     state_q, state_d;
  logic [LW-1:0] left_q, left_d;
  logic [LW-1:0] grab;

  // payload size frozen at packet start
  assign grab = (fill > CW'(MAX_PAY)) ? LW'(MAX_PAY) : fill[LW-1:0];

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    pkt_valid = 1'b0;
    pkt_data  = 8'h00;
    pkt_last  = 1'b0;
    rd_en     = 1'b0;
    ka_take   = 1'b0;
    data_done = 1'b0;
    case (state_q)
      PK_IDLE: begin
        if (!link_busy) begin
          if (fill != '0) begin
            left_d  = grab;
            state_d = PK_HDRA;
          end else if (ka_pending) begin
            left_d  = '0;
            ka_take = 1'b1;
            state_d = PK_HDRA;
          end
        end
      end
      PK_HDRA: begin
        pkt_valid = 1'b1;
        pkt_data  = HDR_A;
        if (pkt_ready) begin
          state_d = PK_HDRB;
        end
      end
      PK_HDRB: begin
        pkt_valid = 1'b1;
        pkt_data  = HDR_B;
        pkt_last  = (left_q == '0);
        if (pkt_ready) begin
          state_d = (left_q == '0) ? PK_IDLE : PK_BODY;
        end
      end
      PK_BODY: begin
        pkt_valid = 1'b1;
        pkt_data  = rd_data;
        pkt_last  = (left_q == LW'(1));
        if (pkt_ready) begin
          rd_en  = 1'b1;
          left_d = left_q - LW'(1);
          if (left_q == LW'(1)) begin
            data_done = 1'b1;
            state_d   = PK_IDLE;
          end
        end
      end
      default: state_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PK_IDLE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end

endmodule

// File: rtl/pk_response_packetizer.sv
module pk_response_packetizer #(
  parameter int         CLK_HZ   = 48000000,
  parameter int         TICK_HZ  = 100,
  parameter int         AW       = 8,
  parameter int         MAX_PAY  = 62,
  parameter int         HEADROOM = 63,
  parameter logic [7:0] HDR_A    = 8'h31,
  parameter logic [7:0] HDR_B    = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       link_busy,
  input  logic       pkt_ready,
  output logic       pkt_valid,
  output logic [7:0] pkt_data,
  output logic       pkt_last,
  output logic       accept_more,
  output logic       overflow
);

  localparam int DEPTH  = 1 << AW;
  localparam int CW     = AW + 1;
  localparam int PERIOD = CLK_HZ / TICK_HZ;
  localparam logic [CW-1:0] THRESH = CW'(DEPTH - HEADROOM);

  logic [7:0]    rd_data;
  logic [CW-1:0] fill;
  logic          rd_en;
  logic          drop;
  logic          tick;
  logic          ka_take;
  logic          data_done;
  logic          ka_q, ka_d;
  logic          ovf_q, ovf_d;

  pk_ring #(.AW(AW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .fill    (fill),
    .drop    (drop)
  );

  pk_tick #(.PERIOD(PERIOD)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  pk_former #(
    .CW      (CW),
    .MAX_PAY (MAX_PAY),
    .HDR_A   (HDR_A),
    .HDR_B   (HDR_B)
  ) u_former (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_busy  (link_busy),
    .fill       (fill),
    .ka_pending (ka_q),
    .rd_data    (rd_data),
    .pkt_ready  (pkt_ready),
    .pkt_valid  (pkt_valid),
    .pkt_data   (pkt_data),
    .pkt_last   (pkt_last),
    .rd_en      (rd_en),
    .ka_take    (ka_take),
    .data_done  (data_done)
  );

  // a fresh request (tick or finished data packet) outranks a take
  always_comb begin
    ka_d  = tick | data_done | (ka_q & ~ka_take);
    ovf_d = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ka_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ka_q  <= ka_d;
      ovf_q <= ovf_d;
    end
  end

  assign accept_more = (fill < THRESH);
  assign overflow    = ovf_q;

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int         MAX_PAY = 62,
  parameter logic [7:0] HDR_A   = 8'h31,
  parameter logic [7:0] HDR_B   = 8'h60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic [7:0] pkt_data,
  input logic       pkt_last,
  input logic       link_busy,
  input logic       overflow
);

  localparam int MAX_LEN = MAX_PAY + 2;
  localparam int PW = $clog2(MAX_LEN + 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pkt_valid && pkt_ready) begin
      pos_q <= pkt_last ? '0 : pos_q + PW'(1);
    end
  end

  assert_hdr_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pos_q == '0) |-> (pkt_data == HDR_A));

  assert_hdr_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pos_q == PW'(1)) |-> (pkt_data == HDR_B));

  assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pos_q == PW'(MAX_LEN - 1)) |-> pkt_last);

  assert_no_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pos_q == '0) |-> !pkt_last);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  assert_busy_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_busy && !pkt_valid) |=> !pkt_valid);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind pk_response_packetizer pk_checker #(
  .MAX_PAY (MAX_PAY),
  .HDR_A   (HDR_A),
  .HDR_B   (HDR_B)
) u_pk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_data  (pkt_data),
  .pkt_last  (pkt_last),
  .link_busy (link_busy),
  .overflow  (overflow)
);

// File: tb/tb_pk_response_packetizer.sv
module tb_pk_response_packetizer;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       link_busy;
  logic       pkt_ready;
  logic       pkt_valid;
  logic [7:0] pkt_data;
  logic       pkt_last;
  logic       accept_more;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0] seq = 8'h00;
  logic [7:0] exp_q[$];
  int len_q[$];
  int start_q[$];
  int end_q[$];
  int pos = 0;
  int cur_start = 0;

  pk_response_packetizer #(
    .CLK_HZ  (4000),
    .TICK_HZ (100)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .link_busy   (link_busy),
    .pkt_ready   (pkt_ready),
    .pkt_valid   (pkt_valid),
    .pkt_data    (pkt_data),
    .pkt_last    (pkt_last),
    .accept_more (accept_more),
    .overflow    (overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      if (pos == 0) begin
        cur_start = cyc;
        chk(pkt_data == 8'h31, "R1", pkt_data, 8'h31);
      end else if (pos == 1) begin
        chk(pkt_data == 8'h60, "R1", pkt_data, 8'h60);
      end else begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", pkt_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pkt_data == e, "R4", pkt_data, e);
        end
      end
      if (pkt_last) begin
        chk(pos >= 1, "R3", pos, 1);
        chk(pos - 1 <= 62, "R2", pos - 1, 62);
        len_q.push_back(pos - 1);
        start_q.push_back(cur_start);
        end_q.push_back(cyc);
        pos = 0;
      end else begin
        pos = pos + 1;
      end
    end
  end

  task automatic push_bytes(input int n, input bit keep);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seq;
      if (keep) exp_q.push_back(seq);
      seq = seq + 8'd1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic quiesce();
    link_busy = 1'b1;
    pkt_ready = 1'b1;
    repeat (70) @(negedge clk);
    len_q.delete();
    start_q.delete();
    end_q.delete();
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_lens(input string req, input int l0, input int l1, input int l2);
    chk(len_q.size() >= 3, req, len_q.size(), 3);
    if (len_q.size() >= 3) begin
      chk(len_q[0] == l0, req, len_q[0], l0);
      chk(len_q[1] == l1, req, len_q[1], l1);
      chk(len_q[2] == l2, req, len_q[2], l2);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    wait_cycles(3);
    // R10: state held in reset
    chk(pkt_valid == 1'b0, "R10", pkt_valid, 0);
    chk(accept_more == 1'b1, "R10", accept_more, 1);
    chk(overflow == 1'b0, "R10", overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R10", pkt_valid, 0);
    chk(overflow == 1'b0, "R10", overflow, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    link_busy = 1'b0;
    pkt_ready = 1'b1;
    @(negedge clk);
    do_reset();

    // R5: idle keepalive spacing
    wait_cycles(130);
    chk(len_q.size() >= 2, "R5", len_q.size(), 2);
    if (len_q.size() >= 2) begin
      int n;
      n = len_q.size();
      chk(len_q[n-1] == 0 && len_q[n-2] == 0, "R5", len_q[n-1], 0);
      chk(start_q[n-1] - start_q[n-2] == 40, "R5", start_q[n-1] - start_q[n-2], 40);
    end

    // R7 and R6: busy holds back, then data followed by keepalive
    quiesce();
    push_bytes(5, 1'b1);
    wait_cycles(10);
    chk(len_q.size() == 0, "R7", len_q.size(), 0);
    chk(pkt_valid == 1'b0, "R7", pkt_valid, 0);
    link_busy = 1'b0;
    wait_cycles(30);
    chk(len_q.size() >= 2, "R6", len_q.size(), 2);
    if (len_q.size() >= 2) begin
      chk(len_q[0] == 5, "R6", len_q[0], 5);
      chk(len_q[1] == 0, "R6", len_q[1], 0);
      chk(start_q[1] - end_q[0] == 2, "R6", start_q[1] - end_q[0], 2);
    end

    // R2: 100 pending split 62 + 38, then keepalive
    quiesce();
    push_bytes(100, 1'b1);
    link_busy = 1'b0;
    wait_cycles(140);
    check_lens("R2", 62, 38, 0);

    // R2 and R3: length frozen at start, bytes held under backpressure
    quiesce();
    pkt_ready = 1'b0;
    push_bytes(3, 1'b1);
    link_busy = 1'b0;
    wait_cycles(2);
    chk(pkt_valid == 1'b1 && pkt_data == 8'h31, "R3", pkt_data, 8'h31);
    push_bytes(4, 1'b1);
    chk(pkt_valid == 1'b1 && pkt_data == 8'h31 && pkt_last == 1'b0, "R3", pkt_data, 8'h31);
    pkt_ready = 1'b1;
    wait_cycles(30);
    check_lens("R2", 3, 4, 0);

    // R8 and R9: throttle threshold, full buffer, drop, wrap
    quiesce();
    push_bytes(192, 1'b1);
    chk(accept_more == 1'b1, "R8", accept_more, 1);
    chk(overflow == 1'b0, "R9", overflow, 0);
    push_bytes(1, 1'b1);
    chk(accept_more == 1'b0, "R8", accept_more, 0);
    push_bytes(63, 1'b1);
    chk(overflow == 1'b0, "R9", overflow, 0);
    push_bytes(1, 1'b0);
    chk(overflow == 1'b1, "R9", overflow, 1);
    chk(accept_more == 1'b0, "R8", accept_more, 0);
    link_busy = 1'b0;
    wait_cycles(400);
    chk(len_q.size() >= 6, "R4", len_q.size(), 6);
    if (len_q.size() >= 6) begin
      for (int k = 0; k < 4; k++) chk(len_q[k] == 62, "R2", len_q[k], 62);
      chk(len_q[4] == 8, "R2", len_q[4], 8);
      chk(len_q[5] == 0, "R6", len_q[5], 0);
    end
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    chk(overflow == 1'b1, "R9", overflow, 1);
    chk(accept_more == 1'b1, "R8", accept_more, 1);

    // R9 / R10: reset clears the sticky flag
    do_reset();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule